// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block decides where a 32-bit integer core fetches next and what value a control-flow or PC-relative operation writes back. Each cycle it takes the current program counter, two register operands, a sign-extended immediate, a control class and a comparison kind. From these it produces four results:

- the next program counter;
- a flag that says the flow was redirected;
- the value for the destination register;
- a flag for a redirect target that is not 4-byte aligned.

Every instruction is 4 bytes long. All results are registered, so they appear one clock after the inputs are sampled. Fetch, decode, the register file and trap handling live elsewhere. The misalignment flag only reports the condition and does not change the next PC.

Top module: `bnpc_unit`

## Requirements
- R1: A synchronous active-high `rst` sets, at the next rising edge: `next_pc_o` to the parameter RST_VECTOR (default 0), and `taken_o`, `wb_o` and `misalign_o` to zero.
- R2: Outputs are registered. They show the result of the inputs sampled at the previous rising edge and do not change between edges.
- R3: Control class codes on `cls_i` are: 0 sequential, 1 conditional branch, 2 direct jump, 3 register-indirect jump, 4 PC-relative upper immediate, 5 load upper immediate. Class 0 and the unused codes 6 and 7 give `next_pc_o` = pc+4, `taken_o` = 0, `wb_o` = 0 and `misalign_o` = 0.
- R4: For class 1, `cmp_i` selects the test on opa and opb: 0 equal, 1 not equal, 2 signed less than, 3 signed greater or equal, 4 unsigned less than, 5 unsigned greater or equal. If the test holds, `next_pc_o` = pc+imm and `taken_o` = 1; otherwise `next_pc_o` = pc+4 and `taken_o` = 0. `wb_o` is 0.
- R5: Signed tests treat the operands as two's complement, so 0x80000000 is below 0x7FFFFFFF. Unsigned tests treat them as plain magnitudes, so 0xFFFFFFFF is the largest value.
- R6: Class 2 gives `next_pc_o` = pc+imm, `taken_o` = 1 and `wb_o` = pc+4.
- R7: Class 3 gives `next_pc_o` = (opa+imm) with bit 0 cleared, `taken_o` = 1 and `wb_o` = pc+4.
- R8: Class 4 gives `wb_o` = pc+imm, `next_pc_o` = pc+4 and `taken_o` = 0.
- R9: Class 5 gives `wb_o` = imm, `next_pc_o` = pc+4 and `taken_o` = 0.
- R10: `misalign_o` is 1 exactly when `taken_o` is 1 and bit 1 of `next_pc_o` is 1. An untaken operation never raises it.
- R11: For class 1, the unused comparison codes 6 and 7 are never taken.
- R12: All address and link sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Current program counter |
| opa_i | input | 32 | First register operand (also the indirect jump base) |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 32 | Sign-extended immediate or offset |
| cls_i | input | 3 | Control class code |
| cmp_i | input | 3 | Branch comparison kind |
| next_pc_o | output | 32 | Registered next program counter |
| taken_o | output | 1 | Registered redirect flag |
| wb_o | output | 32 | Registered destination-register value |
| misalign_o | output | 1 | Registered misaligned-redirect flag |

## Verification
Every comparison kind is tried on all pairs of 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. These pairs separate signed from unsigned ordering and equal from unequal operands, which exposes a swapped or wrongly signed test. A fixed table covers each class, wrap-around past 0xFFFFFFFC, the cleared low bit of an odd indirect target, and targets with bit 1 set that are taken or not taken. Random operands, immediates and classes are then checked against a reference model. Directed cases cover reset, the unused codes, and the one-cycle hold of the registered outputs.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;
  localparam int CLS_W = 3;
  localparam int CMP_W = 3;

  localparam logic [CLS_W-1:0] CLS_SEQ    = 3'd0;
  localparam logic [CLS_W-1:0] CLS_BRANCH = 3'd1;
  localparam logic [CLS_W-1:0] CLS_JUMP   = 3'd2;
  localparam logic [CLS_W-1:0] CLS_JREG   = 3'd3;
  localparam logic [CLS_W-1:0] CLS_PCREL  = 3'd4;
  localparam logic [CLS_W-1:0] CLS_LUPPER = 3'd5;

  localparam logic [CMP_W-1:0] CMP_EQ  = 3'd0;
  localparam logic [CMP_W-1:0] CMP_NE  = 3'd1;
  localparam logic [CMP_W-1:0] CMP_LT  = 3'd2;
  localparam logic [CMP_W-1:0] CMP_GE  = 3'd3;
  localparam logic [CMP_W-1:0] CMP_LTU = 3'd4;
  localparam logic [CMP_W-1:0] CMP_GEU = 3'd5;
endpackage

// File: rtl/bnpc_compare.sv
module bnpc_compare
  import bnpc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  input  logic [CMP_W-1:0] kind,
  output logic             hit
);
  // One subtractor serves both orderings.
  logic [W:0] diff;
  logic       is_eq;
  logic       lt_u;
  logic       lt_s;

  always_comb begin
    diff  = {1'b0, opa} - {1'b0, opb};
    is_eq = (opa == opb);
    lt_u  = diff[W];
    // Different signs: the negative operand is lower. Same signs: the
    // unsigned ordering is also the signed one.
    lt_s  = (opa[W-1] ^ opb[W-1]) ? opa[W-1] : lt_u;
  end

  always_comb begin
    unique case (kind)
      CMP_EQ:  hit = is_eq;
      CMP_NE:  hit = !is_eq;
      CMP_LT:  hit = lt_s;
      CMP_GE:  hit = !lt_s;
      CMP_LTU: hit = lt_u;
      CMP_GEU: hit = !lt_u;
      default: hit = 1'b0;   // codes 6 and 7: never taken (R11)
    endcase
  end
endmodule

// File: rtl/bnpc_target.sv
module bnpc_target #(
  parameter int W    = 32,
  parameter int ILEN = 4
) (
  input  logic [W-1:0] pc,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] imm,
  output logic [W-1:0] seq_pc,
  output logic [W-1:0] rel_pc,
  output logic [W-1:0] reg_pc
);
  localparam logic [W-1:0] STEP = W'(ILEN);

  logic [W-1:0] reg_sum;

  always_comb begin
    seq_pc  = pc + STEP;
    rel_pc  = pc + imm;
    reg_sum = opa + imm;
    reg_pc  = {reg_sum[W-1:1], 1'b0};
  end
endmodule

// File: rtl/bnpc_select.sv
module bnpc_select
  import bnpc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [CLS_W-1:0] cls,
  input  logic             cond_hit,
  input  logic [W-1:0]     imm,
  input  logic [W-1:0]     seq_pc,
  input  logic [W-1:0]     rel_pc,
  input  logic [W-1:0]     reg_pc,
  output logic [W-1:0]     nxt,
  output logic             tkn,
  output logic [W-1:0]     wbv,
  output logic             mis
);
  always_comb begin
    nxt = seq_pc;
    tkn = 1'b0;
    wbv = '0;
    unique case (cls)
      CLS_BRANCH: begin
        tkn = cond_hit;
        nxt = cond_hit ? rel_pc : seq_pc;
      end
      CLS_JUMP: begin
        tkn = 1'b1;
        nxt = rel_pc;
        wbv = seq_pc;
      end
      CLS_JREG: begin
        tkn = 1'b1;
        nxt = reg_pc;
        wbv = seq_pc;
      end
      CLS_PCREL:  wbv = rel_pc;
      CLS_LUPPER: wbv = imm;
      default: ;
    endcase
    mis = tkn & nxt[1];
  end
endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
  import bnpc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          ILEN       = 4,
  parameter logic [31:0] RST_VECTOR = 32'h0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  input  logic [XLEN-1:0]  imm_i,
  input  logic [CLS_W-1:0] cls_i,
  input  logic [CMP_W-1:0] cmp_i,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             taken_o,
  output logic [XLEN-1:0]  wb_o,
  output logic             misalign_o
);
  localparam logic [XLEN-1:0] STEP   = XLEN'(ILEN);
  localparam logic [XLEN-1:0] RST_PC = XLEN'(RST_VECTOR);

  logic            cond_hit;
  logic [XLEN-1:0] seq_pc, rel_pc, reg_pc;
  logic [XLEN-1:0] nxt_d, wb_d;
  logic            tkn_d, mis_d;

  bnpc_compare #(.W(XLEN)) u_cmp (
    .opa(opa_i), .opb(opb_i), .kind(cmp_i), .hit(cond_hit)
  );

  bnpc_target #(.W(XLEN), .ILEN(ILEN)) u_tgt (
    .pc(pc_i), .opa(opa_i), .imm(imm_i),
    .seq_pc(seq_pc), .rel_pc(rel_pc), .reg_pc(reg_pc)
  );

  bnpc_select #(.W(XLEN)) u_sel (
    .cls(cls_i), .cond_hit(cond_hit), .imm(imm_i),
    .seq_pc(seq_pc), .rel_pc(rel_pc), .reg_pc(reg_pc),
    .nxt(nxt_d), .tkn(tkn_d), .wbv(wb_d), .mis(mis_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc_o  <= RST_PC;
      taken_o    <= 1'b0;
      wb_o       <= '0;
      misalign_o <= 1'b0;
    end else begin
      next_pc_o  <= nxt_d;
      taken_o    <= tkn_d;
      wb_o       <= wb_d;
      misalign_o <= mis_d;
    end
  end

  AST_RESET_VALUES: assert property (@(posedge clk)
    rst |=> (next_pc_o == RST_PC && !taken_o && wb_o == '0 && !misalign_o)); // R1

  AST_SEQ_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    (cls_i == CLS_SEQ) |=> (next_pc_o == $past(pc_i) + STEP && !taken_o)); // R3

  AST_JREG_LSB_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cls_i == CLS_JREG) |=> (next_pc_o[0] == 1'b0 && taken_o)); // R7

  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
    (cls_i == CLS_JUMP || cls_i == CLS_JREG) |=> (wb_o == $past(pc_i) + STEP)); // R6

  AST_NO_REDIRECT_UPPER: assert property (@(posedge clk) disable iff (rst)
    (cls_i == CLS_PCREL || cls_i == CLS_LUPPER) |=> (!taken_o && !misalign_o)); // R8

  AST_MISALIGN_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    misalign_o |-> (taken_o && next_pc_o[1])); // R10
endmodule

// File: tb/bnpc_unit_tb.sv
module bnpc_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  localparam int NRAND = 300;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pc_i, opa_i, opb_i, imm_i;
  logic [2:0]  cls_i, cmp_i;
  logic [31:0] next_pc_o, wb_o;
  logic        taken_o, misalign_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bnpc_unit u_dut (
    .clk(clk), .rst(rst), .pc_i(pc_i), .opa_i(opa_i), .opb_i(opb_i),
    .imm_i(imm_i), .cls_i(cls_i), .cmp_i(cmp_i), .next_pc_o(next_pc_o),
    .taken_o(taken_o), .wb_o(wb_o), .misalign_o(misalign_o)
  );

  // Row layout: {cls, cmp, pc, opa, opb, imm}
  localparam logic [133:0] VEC [0:NVEC-1] = '{
    {3'd0, 3'd0, 32'h0000_1000, 32'h5, 32'h6, 32'h40},          // R3 sequential
    {3'd0, 3'd0, 32'hFFFF_FFFC, 32'h0, 32'h0, 32'h0},           // R12 wrap
    {3'd1, 3'd0, 32'h0000_2000, 32'h7, 32'h7, 32'hFFFF_FFF0},   // R4 eq taken back
    {3'd1, 3'd1, 32'h0000_2000, 32'h7, 32'h7, 32'h20},          // R4 ne not taken
    {3'd1, 3'd2, 32'h0000_2000, 32'hFFFF_FFFF, 32'h1, 32'h8},   // R5 -1 < 1 signed
    {3'd1, 3'd4, 32'h0000_2000, 32'hFFFF_FFFF, 32'h1, 32'h8},   // R5 not below unsigned
    {3'd1, 3'd0, 32'h0000_3000, 32'h3, 32'h3, 32'h6},           // R10 taken odd target
    {3'd1, 3'd1, 32'h0000_3000, 32'h3, 32'h3, 32'h6},           // R10 untaken no flag
    {3'd2, 3'd0, 32'h0000_4000, 32'h0, 32'h0, 32'h0000_0100},   // R6 jump
    {3'd2, 3'd0, 32'hFFFF_FFFC, 32'h0, 32'h0, 32'h8},           // R12 jump wrap
    {3'd3, 3'd0, 32'h0000_5000, 32'h0000_8001, 32'h0, 32'h4},   // R7 odd target
    {3'd3, 3'd0, 32'h0000_5000, 32'h0000_8000, 32'h0, 32'h3},   // R7 misaligned
    {3'd4, 3'd0, 32'h0000_6000, 32'h0, 32'h0, 32'h1234_5000},   // R8 pc-relative
    {3'd4, 3'd0, 32'h0000_6000, 32'h0, 32'h0, 32'h2},           // R8 no flag
    {3'd5, 3'd0, 32'h0000_7000, 32'h9, 32'h9, 32'hABCD_E000},   // R9 load upper
    {3'd7, 3'd0, 32'h0000_7000, 32'h9, 32'h9, 32'h10}           // R3 unused class
  };

  localparam logic [31:0] BND [0:3] = '{32'h0, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

  // Expected result {next, taken, wb, misalign}, written from the requirements.
  function automatic logic [65:0] ref_model(input logic [2:0] c, input logic [2:0] k,
                                             input logic [31:0] pc, input logic [31:0] a,
                                             input logic [31:0] b, input logic [31:0] imm);
    logic [31:0] nx, wb;
    logic tk, cond;
    case (k)
      3'd0: cond = (a == b);
      3'd1: cond = (a != b);
      3'd2: cond = ($signed(a) < $signed(b));
      3'd3: cond = ($signed(a) >= $signed(b));
      3'd4: cond = (a < b);
      3'd5: cond = (a >= b);
      default: cond = 1'b0;
    endcase
    nx = pc + 32'd4;
    tk = 1'b0;
    wb = 32'h0;
    case (c)
      3'd1: if (cond) begin nx = pc + imm; tk = 1'b1; end
      3'd2: begin nx = pc + imm; tk = 1'b1; wb = pc + 32'd4; end
      3'd3: begin nx = (a + imm) & 32'hFFFF_FFFE; tk = 1'b1; wb = pc + 32'd4; end
      3'd4: wb = pc + imm;
      3'd5: wb = imm;
      default: ;
    endcase
    return {nx, tk, wb, tk & nx[1]};
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd1: return "R4 R5 R10";
      3'd2: return "R6 R10 R12";
      3'd3: return "R7 R10";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R3 R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [65:0] got, input logic [65:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got next=%h tk=%b wb=%h mis=%b, expected next=%h tk=%b wb=%h mis=%b",
               tag, got[65:34], got[33], got[32:1], got[0],
               exp[65:34], exp[33], exp[32:1], exp[0]);
    end
  endtask

  function automatic logic [65:0] outs();
    return {next_pc_o, taken_o, wb_o, misalign_o};
  endfunction

  task automatic apply(input logic [2:0] c, input logic [2:0] k, input logic [31:0] pc,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] imm,
                       input string tag);
    @(negedge clk);
    cls_i = c; cmp_i = k; pc_i = pc; opa_i = a; opb_i = b; imm_i = imm;
    @(negedge clk);
    check(tag, outs(), ref_model(c, k, pc, a, b, imm));
  endtask

  initial begin
    logic [65:0] held;
    rst = 1'b1;
    cls_i = 3'd2; cmp_i = 3'd0; pc_i = 32'h100; opa_i = 0; opb_i = 0; imm_i = 32'h40;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset", outs(), 66'h0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++)
      apply(VEC[i][133:131], VEC[i][130:128], VEC[i][127:96], VEC[i][95:64],
            VEC[i][63:32], VEC[i][31:0], tag_of(VEC[i][133:131]));

    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          apply(3'd1, 3'(k), 32'h0000_1000, BND[i], BND[j], 32'h10, "R4 R5 boundary");

    apply(3'd1, 3'd6, 32'h800, 32'h1, 32'h1, 32'h20, "R11 code 6");
    apply(3'd1, 3'd7, 32'h800, 32'h1, 32'h2, 32'h20, "R11 code 7");
    apply(3'd6, 3'd0, 32'h800, 32'h1, 32'h1, 32'h20, "R3 class 6");

    // R2: outputs hold until the next rising edge.
    @(negedge clk);
    held = outs();
    cls_i = 3'd2; pc_i = 32'h0000_9000; imm_i = 32'h100;
    #1;
    check("R2 hold before edge", outs(), held);
    @(negedge clk);
    check("R2 update after edge", outs(), ref_model(3'd2, cmp_i, 32'h9000, opa_i, opb_i, 32'h100));

    for (int n = 0; n < NRAND; n++)
      apply(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), $urandom, $urandom,
            ($urandom_range(0, 3) == 0) ? opa_i : $urandom, $urandom, "R4 R6 R7 R8 R9 random");

    // R1: reset in the middle of the run wins over a jump.
    @(negedge clk);
    rst = 1'b1; cls_i = 3'd2; pc_i = 32'h4444_0000; imm_i = 32'h6;
    @(negedge clk);
    check("R1 mid-run reset", outs(), 66'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule